// File: doc/BRIEF.md
# Flash Lock Survey and Unlock Sequencer

This block sits on the host side of a byte-wide parallel flash bus. When it sees a start pulse, it checks the device's lock state. First it switches the device into identifier mode and reads the master lock byte. Then it visits every erase block and reads that block's lock byte. The device is then returned to array-read mode. If blocks are locked and the master lock allows it, the block sends the command pair that clears all block locks.

Two block maps are supported, chosen at start:
- **Uniform:** every block is 64 KB.
- **Boot-sector:** the first 64 KB is split into eight 8 KB blocks, and 64 KB blocks follow.

The device size is given in 64 KB units and marks the end of the walk. An optional mode polls the device status until it is ready, both before the survey and after an unlock.

The block ends the run with a one-cycle done pulse. It then holds the locked-block count, the master lock state, whether an unlock was issued, and a pass/fail verdict until the next start.

Top module: `flash_lock_seq`

## Requirements
- R1: Every access holds `bus_req_o`, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` steady until `bus_ack_i`. Exactly one access completes per acknowledged request.
- R2: `start_i` is accepted only while idle. The map, wait-mode and size inputs are latched at that moment. A start pulse during a run has no effect on the access sequence or the results.
- R3: Without wait mode, a run begins by writing 0x50 and then 0x90 to address 0, then reads address 3. Any nonzero byte there means the master lock is set.
- R4: Block lock bytes are read at block base + 2.
  - In the uniform map, bases step by 0x10000.
  - In the boot map, bases step by 0x2000 while below 0x10000 and by 0x10000 after that.
  - The walk stops at the first base that is not below `size_i` × 0x10000. A size of 0 reads no block.
- R5: `lock_cnt_o` equals the number of block lock bytes that read nonzero.
- R6: After the last block read, 0xFF is written to address 0.
- R7: If the master lock is clear and at least one block is locked, the block writes 0x60, 0xD0 and 0xFF to address 0, and `unlock_o` is set. In every other case, no unlock command is sent and `unlock_o` stays low.
- R8: `pass_o` is low exactly when the master lock is set and at least one block is locked.
- R9: With wait mode, the opening 0x50 is replaced by a ready wait. A ready wait is: write 0x70 to address 0, read address 0 until bit 7 is 1, then write 0xFF to address 0. A second ready wait follows an unlock.
- R10: `done_o` is high for exactly one cycle, the cycle after the last access is acknowledged. The result outputs stay stable from then until the next accepted start.
- R11: Under reset, `bus_req_o`, `done_o`, `pass_o`, `master_lock_o`, `unlock_o` and `lock_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a survey (idle only) |
| boot_map_i | input | 1 | 1 = boot-sector block map, 0 = uniform |
| wait_rdy_i | input | 1 | 1 = poll for device ready before the survey and after an unlock |
| size_i | input | ADDR_W-16 | Device size in 64 KB units |
| bus_req_o | output | 1 | Access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Byte address |
| bus_wdata_o | output | 8 | Write data / command byte |
| bus_rdata_i | input | 8 | Read data, valid with ack |
| bus_ack_i | input | 1 | Access complete |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Verdict: 1 = pass |
| master_lock_o | output | 1 | Master lock was found set |
| unlock_o | output | 1 | Unlock commands were sent |
| lock_cnt_o | output | ADDR_W-15 | Number of locked blocks found |

## Verification
With a responder that acknowledges one cycle after the request, each access takes two cycles. `done_o` is therefore due exactly 2N+1 cycles after the start edge, where N is the number of accesses the requirements predict for the case. Status polls count towards N, and the bench's device model reports busy a fixed number of times.

The bench works out N and the full expected access list before each run. It samples on falling edges, requires `done_o` on exactly that cycle, and reads the verdict outputs in the same cycle. It reads them again three cycles later to confirm they have held and that no second pulse has appeared.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_ARRAY      = 8'hFF;
  localparam logic [7:0] CMD_UNLK_SETUP = 8'h60;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;

  localparam int unsigned MASTER_OFS = 3;
  localparam int unsigned LOCK_OFS   = 2;
  localparam int unsigned SMALL_SH   = 13;  // 8 KB boot block
  localparam int unsigned LARGE_SH   = 16;  // 64 KB main block
  localparam int unsigned READY_BIT  = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE_STAT, ST_PRE_POLL, ST_PRE_ARR,
    ST_CLR, ST_ID, ST_MASTER, ST_BLOCK, ST_ARR,
    ST_UNL_SET, ST_UNL_CFM, ST_UNL_ARR,
    ST_POST_STAT, ST_POST_POLL, ST_POST_ARR, ST_FIN
  } seq_st_e;
endpackage

// File: rtl/lock_block_walker.sv
module lock_block_walker
  import flash_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  localparam int unsigned SIZE_W = ADDR_W - LARGE_SH,
  localparam int unsigned BW = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  input  logic              boot_map_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              at_end_o,
  output logic              last_o
);
  localparam logic [BW-1:0] SMALL_STEP = {{(BW-SMALL_SH-1){1'b0}}, 1'b1, {SMALL_SH{1'b0}}};
  localparam logic [BW-1:0] LARGE_STEP = {{(BW-LARGE_SH-1){1'b0}}, 1'b1, {LARGE_SH{1'b0}}};

  logic [BW-1:0] base_q, limit, step_amt, next_base;

  assign limit     = {1'b0, size_i, {LARGE_SH{1'b0}}};
  // boot map: small steps until the first 64 KB boundary
  assign step_amt  = (boot_map_i && (base_q < LARGE_STEP)) ? SMALL_STEP : LARGE_STEP;
  assign next_base = base_q + step_amt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_q <= '0;
    else if (init_i) base_q <= '0;
    else if (step_i) base_q <= next_base;
  end

  assign base_o   = base_q[ADDR_W-1:0];
  assign at_end_o = (base_q >= limit);
  assign last_o   = (next_base >= limit);

  AST_STEP_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !at_end_o); // R4
  AST_BASE_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !init_i) |=> (base_q > $past(base_q))); // R4
  AST_UNIFORM_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_map_i |-> (base_q[LARGE_SH-1:0] == '0)); // R4
endmodule

// File: rtl/lock_verdict.sv
module lock_verdict #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             master_vld_i,
  input  logic             blk_vld_i,
  input  logic [7:0]       rdata_i,
  output logic             master_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pass_rule_o,
  output logic             need_unlock_o
);
  logic             master_q;
  logic [CNT_W-1:0] cnt_q;
  logic             any_lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      cnt_q    <= '0;
    end else if (clear_i) begin
      master_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (master_vld_i)             master_q <= |rdata_i;
      if (blk_vld_i && (|rdata_i))  cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign any_lock      = (cnt_q != '0);
  assign master_o      = master_q;
  assign cnt_o         = cnt_q;
  assign pass_rule_o   = !(master_q && any_lock);
  assign need_unlock_o = !master_q && any_lock;

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_vld_i && (|rdata_i)) |-> (cnt_q != '1)); // R5
endmodule

// File: rtl/flash_lock_seq.sv
module flash_lock_seq
  import flash_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  localparam int unsigned SIZE_W = ADDR_W - 16,
  localparam int unsigned CNT_W = SIZE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              boot_map_i,
  input  logic              wait_rdy_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic [7:0]        bus_rdata_i,
  input  logic              bus_ack_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              master_lock_o,
  output logic              unlock_o,
  output logic [CNT_W-1:0]  lock_cnt_o
);
  seq_st_e st_q, st_d;
  logic boot_q, wait_q, unlock_q, res_vld_q;
  logic [SIZE_W-1:0] size_q;
  logic start_go, ack_go, ready;
  logic [ADDR_W-1:0] blk_base;
  logic at_end, last_blk;
  logic master, pass_rule, need_unlock;
  logic [CNT_W-1:0] cnt;

  assign start_go = (st_q == ST_IDLE) && start_i;
  assign ack_go   = bus_req_o && bus_ack_i;
  assign ready    = bus_rdata_i[READY_BIT];

  lock_block_walker #(.ADDR_W(ADDR_W)) i_walker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (start_go),
    .step_i     ((st_q == ST_BLOCK) && ack_go),
    .boot_map_i (boot_q),
    .size_i     (size_q),
    .base_o     (blk_base),
    .at_end_o   (at_end),
    .last_o     (last_blk)
  );

  lock_verdict #(.CNT_W(CNT_W)) i_verdict (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (start_go),
    .master_vld_i  ((st_q == ST_MASTER) && ack_go),
    .blk_vld_i     ((st_q == ST_BLOCK) && ack_go),
    .rdata_i       (bus_rdata_i),
    .master_o      (master),
    .cnt_o         (cnt),
    .pass_rule_o   (pass_rule),
    .need_unlock_o (need_unlock)
  );

  // bus fields decoded from state
  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b1;
    bus_addr_o  = '0;
    bus_wdata_o = CMD_ARRAY;
    unique case (st_q)
      ST_IDLE, ST_FIN:             bus_req_o = 1'b0;
      ST_PRE_STAT, ST_POST_STAT:   bus_wdata_o = CMD_READ_STAT;
      ST_PRE_POLL, ST_POST_POLL:   bus_we_o = 1'b0;
      ST_CLR:                      bus_wdata_o = CMD_CLR_STAT;
      ST_ID:                       bus_wdata_o = CMD_READ_ID;
      ST_MASTER: begin
        bus_we_o   = 1'b0;
        bus_addr_o = ADDR_W'(MASTER_OFS);
      end
      ST_BLOCK: begin
        bus_we_o   = 1'b0;
        bus_addr_o = blk_base + ADDR_W'(LOCK_OFS);
      end
      ST_UNL_SET:                  bus_wdata_o = CMD_UNLK_SETUP;
      ST_UNL_CFM:                  bus_wdata_o = CMD_CONFIRM;
      default: ;
    endcase
  end

  always_comb begin
    st_d = st_q;
    if (st_q == ST_IDLE) begin
      if (start_i) st_d = wait_rdy_i ? ST_PRE_STAT : ST_CLR;
    end else if (st_q == ST_FIN) begin
      st_d = ST_IDLE;
    end else if (ack_go) begin
      unique case (st_q)
        ST_PRE_STAT:  st_d = ST_PRE_POLL;
        ST_PRE_POLL:  st_d = ready ? ST_PRE_ARR : ST_PRE_POLL;
        ST_PRE_ARR:   st_d = ST_ID;
        ST_CLR:       st_d = ST_ID;
        ST_ID:        st_d = ST_MASTER;
        ST_MASTER:    st_d = at_end ? ST_ARR : ST_BLOCK;
        ST_BLOCK:     st_d = last_blk ? ST_ARR : ST_BLOCK;
        ST_ARR:       st_d = need_unlock ? ST_UNL_SET : ST_FIN;
        ST_UNL_SET:   st_d = ST_UNL_CFM;
        ST_UNL_CFM:   st_d = ST_UNL_ARR;
        ST_UNL_ARR:   st_d = wait_q ? ST_POST_STAT : ST_FIN;
        ST_POST_STAT: st_d = ST_POST_POLL;
        ST_POST_POLL: st_d = ready ? ST_POST_ARR : ST_POST_POLL;
        ST_POST_ARR:  st_d = ST_FIN;
        default:      st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      boot_q    <= 1'b0;
      wait_q    <= 1'b0;
      size_q    <= '0;
      unlock_q  <= 1'b0;
      res_vld_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_go) begin
        boot_q    <= boot_map_i;
        wait_q    <= wait_rdy_i;
        size_q    <= size_i;
        unlock_q  <= 1'b0;
        res_vld_q <= 1'b0;
      end else begin
        if ((st_q == ST_ARR) && ack_go && need_unlock) unlock_q <= 1'b1;
        if (st_d == ST_FIN) res_vld_q <= 1'b1;
      end
    end
  end

  assign done_o        = (st_q == ST_FIN);
  assign pass_o        = res_vld_q && pass_rule;
  assign master_lock_o = master;
  assign unlock_o      = unlock_q;
  assign lock_cnt_o    = cnt;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o))); // R1
  AST_MODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> ($stable(size_q) && $stable(boot_q) && $stable(wait_q))); // R2
  AST_POLL_UNTIL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_PRE_POLL) && ack_go && !ready) |=> (st_q == ST_PRE_POLL)); // R9
  AST_UNLOCK_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && unlock_o) |-> (pass_o && !master_lock_o && (lock_cnt_o != '0))); // R7
  AST_FAIL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> (master_lock_o && (lock_cnt_o != '0))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
endmodule

// File: tb/test_flash_lock_seq.sv
module test_flash_lock_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int SIZE_W = ADDR_W - 16;
  localparam int CNT_W = SIZE_W + 1;
  localparam int BUSY_N = 2;
  localparam int LOG_N = 1024;
  localparam int EXP_N = 128;
  localparam int NVEC = 8;
  // {boot, wait, size, master byte, lock pattern by block ordinal mod 8}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'd4,  8'h00, 8'h00},
    {1'b0, 1'b0, 8'd4,  8'h00, 8'h05},
    {1'b0, 1'b0, 8'd16, 8'h01, 8'h80},
    {1'b1, 1'b0, 8'd16, 8'h00, 8'hFF},
    {1'b1, 1'b1, 8'd16, 8'h40, 8'h00},
    {1'b1, 1'b1, 8'd1,  8'h00, 8'h10},
    {1'b0, 1'b1, 8'd2,  8'hFF, 8'h02},
    {1'b0, 1'b0, 8'd0,  8'h00, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, boot_map = 1'b0, wait_rdy = 1'b0;
  logic [SIZE_W-1:0] tb_size = '0;
  logic req, we, ack = 1'b0;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wdata, rdata = 8'h00;
  logic done, pass, mlock, unl;
  logic [CNT_W-1:0] cnt;

  logic [127:0] lock_map = '0;
  logic [7:0] master_byte = 8'h00;
  logic id_mode = 1'b0, stat_mode = 1'b0;
  int busy_left = 0;
  int n_log = 0;
  logic lg_we [LOG_N];
  logic [ADDR_W-1:0] lg_addr [LOG_N];
  logic [7:0] lg_wd [LOG_N];
  logic e_we [EXP_N];
  int e_addr [EXP_N];
  logic [7:0] e_wd [EXP_N];
  int e_n = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_lock_seq #(.ADDR_W(ADDR_W)) i_flash_lock_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .boot_map_i(boot_map),
    .wait_rdy_i(wait_rdy), .size_i(tb_size), .bus_req_o(req), .bus_we_o(we),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_ack_i(ack),
    .done_o(done), .pass_o(pass), .master_lock_o(mlock), .unlock_o(unl),
    .lock_cnt_o(cnt)
  );

  // device model: acks one cycle after request, logs every access
  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0; id_mode <= 1'b0; stat_mode <= 1'b0; busy_left <= 0;
    end else if (req && !ack) begin
      ack <= 1'b1;
      if (n_log < LOG_N) begin
        lg_we[n_log] <= we; lg_addr[n_log] <= addr; lg_wd[n_log] <= wdata;
      end
      n_log <= n_log + 1;
      if (we) begin
        if (wdata == 8'h90) begin id_mode <= 1'b1; stat_mode <= 1'b0; end
        else if (wdata == 8'h70) begin stat_mode <= 1'b1; busy_left <= BUSY_N; end
        else if (wdata == 8'hFF) begin id_mode <= 1'b0; stat_mode <= 1'b0; end
      end else if (stat_mode) begin
        rdata <= (busy_left > 0) ? 8'h00 : 8'h80;
        if (busy_left > 0) busy_left <= busy_left - 1;
      end else if (id_mode) begin
        if (addr == 24'd3) rdata <= master_byte;
        else if (addr[1:0] == 2'd2) rdata <= lock_map[addr[19:13]] ? (addr[16] ? 8'h80 : 8'h01) : 8'h00;
        else rdata <= 8'hEE;
      end else begin
        rdata <= 8'hEE;
      end
    end else begin
      ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic push(input logic w, input int a, input logic [7:0] d);
    if (e_n < EXP_N) begin e_we[e_n] = w; e_addr[e_n] = a; e_wd[e_n] = d; end
    e_n++;
  endtask

  task automatic push_wait();
    push(1'b1, 0, 8'h70);
    for (int k = 0; k <= BUSY_N; k++) push(1'b0, 0, 8'h00);
    push(1'b1, 0, 8'hFF);
  endtask

  task automatic run(input logic b, input logic wt, input logic [7:0] sz,
                     input logic [7:0] mb, input logic [7:0] pat, input int poke);
    int base, ord, lk, log0, cyc, bad, first_bad;
    bit mst, x_unl, x_pass;
    logic [CNT_W-1:0] cnt_done;
    logic pass_done, ml_done, unl_done;
    e_n = 0; lock_map = '0; master_byte = mb; lk = 0;
    if (wt) push_wait(); else push(1'b1, 0, 8'h50);
    push(1'b1, 0, 8'h90);
    push(1'b0, 3, 8'h00);
    base = 0; ord = 0;
    while (base < (int'(sz) << 16)) begin
      lock_map[base >> 13] = pat[ord % 8];
      if (pat[ord % 8]) lk++;
      push(1'b0, base + 2, 8'h00);
      base += (b && base < 65536) ? 8192 : 65536;
      ord++;
    end
    push(1'b1, 0, 8'hFF);
    mst = (mb != 8'h00);
    x_unl = !mst && lk > 0;
    x_pass = !(mst && lk > 0);
    if (x_unl) begin
      push(1'b1, 0, 8'h60); push(1'b1, 0, 8'hD0); push(1'b1, 0, 8'hFF);
      if (wt) push_wait();
    end
    log0 = n_log;
    @(negedge clk);
    boot_map = b; wait_rdy = wt; tb_size = sz; start = 1'b1;
    cyc = 0;
    while (cyc < 4000) begin
      @(posedge clk); @(negedge clk);
      start = (poke > 1 && cyc + 1 == poke);
      cyc++;
      if (done) break;
    end
    start = 1'b0;
    chk(done == 1'b1, "R10", "done seen", int'(done), 1);
    chk(cyc == 2 * e_n + 1, "R10", "done latency", cyc, 2 * e_n + 1);
    chk(mlock == mst, "R3", "master lock", int'(mlock), int'(mst));
    chk(int'(cnt) == lk, "R5", "locked count", int'(cnt), lk);
    chk(pass == x_pass, "R8", "pass", int'(pass), int'(x_pass));
    chk(unl == x_unl, "R7", "unlock flag", int'(unl), int'(x_unl));
    bad = 0; first_bad = -1;
    for (int i = 0; i < e_n && i < EXP_N; i++) begin
      if (log0 + i >= LOG_N || lg_we[log0 + i] !== e_we[i] || int'(lg_addr[log0 + i]) != e_addr[i] ||
          (e_we[i] && lg_wd[log0 + i] !== e_wd[i])) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    // sequence covers R1 R3 R4 R6 R7 R9
    chk(n_log - log0 == e_n, "R1 R4 R6 R7 R9", "access count", n_log - log0, e_n);
    chk(bad == 0, "R3 R4 R6 R7 R9", "first mismatching access index", first_bad, -1);
    cnt_done = cnt; pass_done = pass; ml_done = mlock; unl_done = unl;
    repeat (3) @(negedge clk);
    chk(!done && !req && cnt == cnt_done && pass == pass_done && mlock == ml_done && unl == unl_done,
        "R10", "results held, no second done", int'(done), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(!req && !done && !pass && !mlock && !unl && cnt == '0, "R11", "reset outputs",
        int'({req, done, pass, mlock, unl}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req && !done, "R11", "idle after reset", int'({req, done}), 0);
    for (int v = 0; v < NVEC; v++) begin
      run(VEC[v][25], VEC[v][24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 0);
    end
    // R2: start while busy ignored
    run(1'b0, 1'b0, 8'd3, 8'h00, 8'h02, 5);
    run(1'b1, 1'b1, 8'd2, 8'h00, 8'h81, 9);
    // R4: boot map ending exactly at 64 KB with every small block locked
    run(1'b1, 1'b0, 8'd1, 8'h00, 8'hFF, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule